// File: doc/BRIEF.md
# Register Stack with Wrap Flags

This block is a last-in first-out store of `DEPTH` words (64 by default) held in processor registers and addressed by a single stack pointer of `log2(DEPTH)` bits. A caller offers a word on `push_data` with `push_req`, or asks for the top word with `pop_req`. The popped word comes back, registered, one cycle later together with `pop_valid`.

The pointer moves up by one before a push writes, and is read from and then moved down by one on a pop. As a result, the first word pushed onto an empty stack lands in slot 1, and the word that fills the stack lands in slot 0. The full and empty flags are not kept as a separate occupancy count. They are set when the pointer wraps back to zero after a push (full) or after a pop (empty). A push onto a full stack, a pop from an empty stack, or both requests raised together are all reported by a one-cycle error pulse. In the last case the pop is carried out if it is legal and the push is dropped.

Top module: `reg_stack`

## Requirements
- R1: While reset is held and right after it is released, `sp` is 0, `empty` is 1, and `full`, `err`, `pop_valid` and `pop_data` are 0.
- R2: A legal push raises `sp` by one on the next clock edge and stores `push_data` in the slot given by the new pointer value. The first push after empty therefore moves `sp` to 1.
- R3: A legal pop drives the word from the slot at the current `sp` onto `pop_data` with `pop_valid` high in the cycle after the request. `sp` drops by one at that same edge. `pop_data` keeps its value until the next legal pop.
- R4: When a push brings `sp` to 0 (the 64th word with default parameters), `full` becomes 1. Every legal push clears `empty`. `full` and `empty` are never both 1.
- R5: When a pop brings `sp` to 0, `empty` becomes 1. Every legal pop clears `full`.
- R6: A push while `full` (with no pop requested) changes neither `sp`, the flags nor the stored words, and raises `err` for exactly the next cycle.
- R7: A pop while `empty` changes neither `sp`, the flags nor `pop_data`, leaves `pop_valid` low, and raises `err` for exactly the next cycle.
- R8: When push and pop are requested in the same cycle, `err` pulses for one cycle and the push word is dropped. The pop is performed exactly as in R3 unless the stack is empty.
- R9: Across any mix of pushes and pops, each popped word equals the most recent pushed word that has not yet been popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | WIDTH | Word to push |
| pop_data | output | WIDTH | Last popped word, registered |
| pop_valid | output | 1 | High for one cycle after a legal pop |
| sp | output | PTR_W | Stack pointer |
| full | output | 1 | Set when a push wraps the pointer to 0 |
| empty | output | 1 | Set when a pop wraps the pointer to 0, and at reset |
| err | output | 1 | One-cycle pulse after an illegal or conflicting request |

## Verification
The bench drives the pointer through both wraps. It fills all 64 slots, checking that the word in slot 0 comes back first, then drains to empty. A design that derived the flags from the wrong pointer value would set `full` a word early or never. A design that post-incremented would give the last word back out of order. Pushes against a full stack and pops against an empty one are applied before the full drain and before any later pop. A design that did not ignore them would corrupt the pointer or overwrite slot 1, and that shows up in `sp` or in the drained words. Simultaneous requests are issued with the stack empty, full and partly filled. This catches a design that lets the push win or that performs both operations.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  // Decoded request for one cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } rstk_op_e;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             empty,
  output logic             err,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr
);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_ZERO = '0;

  rstk_op_e         op;
  logic [PTR_W-1:0] sp_q, sp_d;
  logic             full_q, full_d;
  logic             empty_q, empty_d;
  logic             err_q, err_d;
  logic [PTR_W-1:0] sp_up, sp_dn;

  assign sp_up = sp_q + PTR_ONE;
  assign sp_dn = sp_q - PTR_ONE;

  // Request decode: pop wins a conflict, illegal ops become OP_BAD.
  always_comb begin
    op = OP_IDLE;
    if (pop_req) begin
      op = empty_q ? OP_BAD : OP_POP;
    end else if (push_req) begin
      op = full_q ? OP_BAD : OP_PUSH;
    end
  end

  // Next-state logic.
  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    err_d   = (op == OP_BAD) || (push_req && pop_req);
    unique case (op)
      OP_PUSH: begin
        sp_d    = sp_up;
        full_d  = (sp_up == PTR_ZERO);
        empty_d = 1'b0;
      end
      OP_POP: begin
        sp_d    = sp_dn;
        empty_d = (sp_dn == PTR_ZERO);
        full_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
      err_q   <= err_d;
    end
  end

  assign sp      = sp_q;
  assign full    = full_q;
  assign empty   = empty_q;
  assign err     = err_q;
  assign wr_en   = (op == OP_PUSH);
  assign wr_addr = sp_up;
  assign rd_en   = (op == OP_POP);
  assign rd_addr = sp_q;

  assert_push_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !full) |=> (sp == $past(sp) + PTR_ONE));
  assert_pop_retreat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty) |=> (sp == $past(sp) - PTR_ONE));
  assert_full_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !full) |=> (!empty && (full == (sp == PTR_ZERO))));
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_empty_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty) |=> (!full && (empty == (sp == PTR_ZERO))));
  assert_push_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> (err && full && $stable(sp)));
  assert_pop_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> (err && empty && $stable(sp)));
  assert_conflict_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> err);
endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [WIDTH-1:0] rd_data_q, rd_data_d;
  logic             rd_valid_q;

  // One register per slot, each with its own write enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_addr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data_d = rd_en ? slot_q[rd_addr] : rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_en;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  assert_no_rw_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

// File: rtl/reg_stack.sv
module reg_stack #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_valid,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             empty,
  output logic             err
);
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  rstk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .pop_req(pop_req),
    .sp(sp), .full(full), .empty(empty), .err(err),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  rstk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(push_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(pop_data), .rd_valid(pop_valid)
  );

  assert_pop_valid_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty) |=> pop_valid);
  assert_no_valid_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> !pop_valid);
endmodule

// File: tb/reg_stack_tb_top.sv
`timescale 1ns/1ps
module reg_stack_tb_top;
  localparam int DEPTH = 64;
  localparam int WIDTH = 8;
  localparam int PTR_W = $clog2(DEPTH);

  logic             clk;
  logic             rst_n;
  logic             push_req, pop_req;
  logic [WIDTH-1:0] push_data;
  logic [WIDTH-1:0] pop_data;
  logic             pop_valid;
  logic [PTR_W-1:0] sp;
  logic             full, empty, err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model: a plain queue of words, top at the back.
  logic [WIDTH-1:0] model_q[$];
  logic [WIDTH-1:0] exp_data = '0;
  bit               exp_valid = 0;
  bit               exp_err = 0;

  reg_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
    .pop_data(pop_data), .pop_valid(pop_valid), .sp(sp),
    .full(full), .empty(empty), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int size = model_q.size();
    check(tag, "sp", int'(sp), size % DEPTH);
    check(tag, "full", int'(full), int'(size == DEPTH));
    check(tag, "empty", int'(empty), int'(size == 0));
    check(tag, "err", int'(err), int'(exp_err));
    check(tag, "pop_valid", int'(pop_valid), int'(exp_valid));
    check(tag, "pop_data", int'(pop_data), int'(exp_data));
  endtask

  // Drive one request at a falling edge, update the model, compare after the next rising edge.
  task automatic step(input bit psh, input bit pp, input logic [WIDTH-1:0] d, input string tag);
    int size = model_q.size();
    push_req  = psh;
    pop_req   = pp;
    push_data = d;
    exp_err   = (psh && pp) || (pp && size == 0) || (psh && !pp && size == DEPTH);
    exp_valid = 0;
    if (pp && size > 0) begin
      exp_data  = model_q.pop_back();
      exp_valid = 1;
    end else if (psh && !pp && size < DEPTH) begin
      model_q.push_back(d);
    end
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0;
    pop_req  = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] wdata;
    int lfsr;
    push_req  = 1'b0;
    pop_req   = 1'b0;
    push_data = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    step(0, 0, 8'h00, "R1");
    step(0, 1, 8'h00, "R7");          // pop from empty
    step(1, 1, 8'h55, "R8");          // conflict while empty
    step(1, 0, 8'hA1, "R2");          // sp to 1
    step(1, 0, 8'hA2, "R2");
    step(1, 0, 8'hA3, "R2");
    step(1, 1, 8'hEE, "R8");          // conflict with data: pop A3
    step(0, 1, 8'h00, "R3");
    step(0, 0, 8'h00, "R3");          // pop_data holds
    step(0, 1, 8'h00, "R5");          // back to empty
    step(0, 1, 8'h00, "R7");

    // Fill completely: last word lands in slot 0
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, WIDTH'(8'h10 + i), (i == DEPTH - 1) ? "R4" : "R2");
    end
    step(1, 0, 8'hFF, "R6");          // push while full
    step(1, 0, 8'hFE, "R6");
    step(1, 1, 8'hFD, "R8");          // conflict while full: pop performed
    step(1, 0, 8'h99, "R4");          // refill
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, 8'h00, (i == 0) ? "R5" : "R9");
    end
    step(0, 1, 8'h00, "R7");

    // Interleaved traffic
    lfsr  = 32'h1ACE5;
    wdata = 8'h01;
    for (int i = 0; i < 3000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 32'h0);
      case (lfsr & 7)
        0, 1, 2, 3: step(1, 0, wdata, "R9");
        4, 5, 6:    step(0, 1, 8'h00, "R9");
        default:    step(1, 1, wdata, "R8");
      endcase
      wdata = wdata + 8'd7;
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule